// File: doc/BRIEF.md
# Region-Select Bridge for Host Target Requests

This block sits behind a host-link endpoint that has already decoded which address window a target request falls in. The endpoint presents a seven-bit window-hit vector, a byte offset, a read/write flag, byte enables and write data. The bridge turns the hit vector straight into one of six local-bus chip selects, runs one access at a time, and returns a completion carrying read data. Bit 6 of the hit vector marks the option-ROM window. The bridge answers that window itself, from a small computed table, so no host read to it can go without a reply.

Each of the six windows is configured at build time as memory-mapped or I/O-mapped. That choice sets the size of the implemented window. It also decides whether a write gets a completion: I/O writes are non-posted and get one, memory writes are posted and do not. Reads that land outside every implemented window complete with all-ones data, as do reads whose local target never answers. The host therefore always sees an answer to a read.

Top module: `barhit_lbus_bridge`

## Requirements
- R1: After reset `req_ready` is 1, `lb_cs` is all zero and `cpl_valid` is 0.
- R2: A request whose lowest set bit among hit bits 0..5 is bit i, and whose offset lies inside window i, drives `lb_cs` one-hot with only bit i set. It drives `lb_addr` with the offset's two low bits cleared and passes `lb_wr` through. A read completes with the `lb_rdata` value sampled with `lb_ready`. When several of bits 0..5 are set, the lowest index wins, and bit 6 is then ignored.
- R3: A window whose bit is set in `BAR_IO` (default: window 2 only) implements `IO_WORDS` words (default 64, byte offsets 0x000..0x0FF). Every other window implements `MEM_WORDS` words (default 1024, byte offsets 0x000..0xFFF). An offset past the implemented size is unimplemented.
- R4: `lb_cs` stays unchanged until `lb_ready` is sampled high, and it is zero in the cycle after. A read completion appears in that same cycle.
- R5: If `lb_ready` has not come after `TIMEOUT` cycles (default 256) with a chip select asserted, the select drops. A read then completes with all-ones data, and an I/O write completes with zero data.
- R6: With hit bits 0..5 clear and bit 6 set, a read of word n is answered by the bridge. It uses no local-bus access and completes in the first cycle after acceptance. Words n below `ROM_WORDS` (16) return {8'h5A, n[7:0], ~n[7:0], n[7:0]^8'h3C}. Words from `ROM_WORDS` up to `ROM_SPAN`-1 (255) return zero. Words beyond that are unimplemented.
- R7: A read with no hit bit set, or to an unimplemented offset, completes with 32'hFFFF_FFFF in the first cycle after acceptance and makes no local-bus access.
- R8: Writes to the option-ROM window, to an unimplemented offset or with no hit bit set never assert a chip select.
- R9: A write to a memory-mapped window produces no completion. A write to an I/O-mapped window produces exactly one completion with zero data: after `lb_ready` if a local access ran, otherwise in the first cycle after acceptance.
- R10: `lb_be` carries the request byte enables. Each `lb_wdata` byte whose enable is 0 is driven as zero. A write with all enables clear makes no local-bus access.
- R11: `req_ready` is low from acceptance until the cycle after the completion cycle. `cpl_valid` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_hit | input | 7 | Window-hit vector, bit 6 = option ROM |
| req_addr | input | AW (16) | Byte offset within the hit window |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion pulse |
| cpl_data | output | 32 | Completion data |
| lb_cs | output | 6 | Local-bus chip selects, one per window |
| lb_addr | output | AW (16) | Word-aligned local offset |
| lb_wr | output | 1 | Local write strobe qualifier |
| lb_be | output | 4 | Local byte enables |
| lb_wdata | output | 32 | Lane-masked write data |
| lb_rdata | input | 32 | Local read data |
| lb_ready | input | 1 | Local access done |

## Verification
The bench probes the last implemented word and the first unimplemented word of both a memory window and the I/O window. A design with an off-by-one limit would either start a local access there or return real data where all-ones is due. It sets several hit bits together, including the option-ROM bit with a normal window. A wrong priority would select the wrong chip select or answer from the table. It starves the local bus so the timeout fires, and it counts exactly how many cycles the select was held. A bridge that hangs, releases early or returns stale data would show up there. It also checks byte-lane zeroing, writes with no enables, and the write-completion split between memory and I/O windows.

// File: rtl/barhit_pkg.sv
package barhit_pkg;
  localparam int NBAR    = 6;
  localparam int HITW    = NBAR + 1;
  localparam int ROM_BIT = NBAR;
  localparam int DW      = 32;
  localparam int BEW     = DW / 8;
  localparam int IDXW    = $clog2(NBAR);

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LBUS = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;

  // Option-ROM word pattern for word index n.
  function automatic logic [DW-1:0] rom_word(input logic [7:0] n);
    return {8'h5A, n, ~n, n ^ 8'h3C};
  endfunction

  // Zero every byte lane whose enable is clear.
  function automatic logic [DW-1:0] lane_gate(input logic [BEW-1:0] be,
                                              input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int b = 0; b < BEW; b++) begin
      r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
    end
    return r;
  endfunction
endpackage

// File: rtl/bh_decode.sv
module bh_decode
  import barhit_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MEM_WORDS = 1024,
  parameter int IO_WORDS  = 64,
  parameter int ROM_SPAN  = 256,
  parameter logic [NBAR-1:0] BAR_IO = 6'b000100
) (
  input  logic [HITW-1:0] hit,
  input  logic [AW-1:0]   addr,
  output tgt_e            tgt,
  output logic [IDXW-1:0] idx,
  output logic            is_io,
  output logic            rom_hit,
  output logic            miss_hit
);
  localparam int WIW = AW - 2;
  localparam logic [WIW:0] MEM_LIM  = (WIW+1)'(MEM_WORDS);
  localparam logic [WIW:0] IO_LIM   = (WIW+1)'(IO_WORDS);
  localparam logic [WIW:0] SPAN_LIM = (WIW+1)'(ROM_SPAN);

  logic [WIW:0] widx;
  logic         found;
  logic         in_win;
  logic         rom_in;

  assign widx = {1'b0, addr[AW-1:2]};

  // lowest set window bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NBAR - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

  assign is_io  = found && BAR_IO[idx];
  assign in_win = is_io ? (widx < IO_LIM) : (widx < MEM_LIM);
  assign rom_in = widx < SPAN_LIM;

  always_comb begin
    if (found && in_win)              tgt = TGT_LBUS;
    else if (!found && hit[ROM_BIT] && rom_in) tgt = TGT_ROM;
    else                              tgt = TGT_NONE;
  end

  assign rom_hit  = (tgt == TGT_ROM);
  assign miss_hit = (tgt == TGT_NONE);
endmodule

// File: rtl/bh_rom.sv
module bh_rom
  import barhit_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ROM_WORDS = 16
) (
  input  logic [AW-3:0]   widx,
  output logic [DW-1:0]   data
);
  localparam int TIW = $clog2(ROM_WORDS);
  localparam logic [AW-2:0] TBL_LIM = (AW-1)'(ROM_WORDS);

  logic [DW-1:0] tbl [ROM_WORDS];

  for (genvar g = 0; g < ROM_WORDS; g++) begin : g_tbl
    assign tbl[g] = rom_word(8'(g));
  end

  assign data = ({1'b0, widx} < TBL_LIM) ? tbl[widx[TIW-1:0]] : '0;
endmodule

// File: rtl/bh_lbus_fsm.sv
module bh_lbus_fsm
  import barhit_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TIMEOUT = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  tgt_e            tgt,
  input  logic [IDXW-1:0] idx,
  input  logic            is_io,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [BEW-1:0]  be,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   imm_data,
  input  logic            lb_ready,
  input  logic [DW-1:0]   lb_rdata,
  output logic [NBAR-1:0] lb_cs,
  output logic [AW-1:0]   lb_addr,
  output logic            lb_wr,
  output logic [BEW-1:0]  lb_be,
  output logic [DW-1:0]   lb_wdata,
  output logic            cpl_valid,
  output logic [DW-1:0]   cpl_data,
  output logic            busy,
  output logic            wd_fire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic {S_IDLE, S_BUS} st_e;

  st_e            state;
  logic [CW-1:0]  cnt;
  logic           cur_wr;
  logic           cur_io;
  logic           go_bus;
  logic           bus_done;
  logic [NBAR-1:0] sel_oh;

  for (genvar i = 0; i < NBAR; i++) begin : g_oh
    assign sel_oh[i] = (idx == IDXW'(i));
  end

  assign go_bus   = acc && (tgt == TGT_LBUS) && !(wr && (be == '0));
  assign busy     = (state == S_BUS);
  assign wd_fire  = busy && !lb_ready && (cnt == LAST);
  assign bus_done = busy && (lb_ready || (cnt == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cur_wr    <= 1'b0;
      cur_io    <= 1'b0;
      lb_cs     <= '0;
      lb_addr   <= '0;
      lb_wr     <= 1'b0;
      lb_be     <= '0;
      lb_wdata  <= '0;
      cpl_valid <= 1'b0;
      cpl_data  <= '0;
    end else begin
      cpl_valid <= 1'b0;
      if (state == S_IDLE) begin
        if (go_bus) begin
          state    <= S_BUS;
          cnt      <= '0;
          cur_wr   <= wr;
          cur_io   <= is_io;
          lb_cs    <= sel_oh;
          lb_addr  <= {addr[AW-1:2], 2'b00};
          lb_wr    <= wr;
          lb_be    <= be;
          lb_wdata <= lane_gate(be, wdata);
        end else if (acc) begin
          if (!wr) begin
            cpl_valid <= 1'b1;
            cpl_data  <= imm_data;
          end else if (is_io) begin
            cpl_valid <= 1'b1;
            cpl_data  <= '0;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (bus_done) begin
          state <= S_IDLE;
          lb_cs <= '0;
          if (!cur_wr) begin
            cpl_valid <= 1'b1;
            cpl_data  <= lb_ready ? lb_rdata : '1;
          end else if (cur_io) begin
            cpl_valid <= 1'b1;
            cpl_data  <= '0;
          end
        end
      end
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lb_cs));

  // R4
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lb_cs != '0) && !lb_ready && !wd_fire) |=> $stable(lb_cs));

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lb_cs != '0) && lb_ready) |=> (lb_cs == '0));

  // R5
  wd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && !cur_wr) |=> (cpl_valid && (cpl_data == '1)));

  // R11
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);
endmodule

// File: rtl/barhit_lbus_bridge.sv
module barhit_lbus_bridge
  import barhit_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MEM_WORDS = 1024,
  parameter int IO_WORDS  = 64,
  parameter int ROM_WORDS = 16,
  parameter int ROM_SPAN  = 256,
  parameter int TIMEOUT   = 256,
  parameter logic [5:0] BAR_IO = 6'b000100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [6:0]    req_hit,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          cpl_valid,
  output logic [31:0]   cpl_data,
  output logic [5:0]    lb_cs,
  output logic [AW-1:0] lb_addr,
  output logic          lb_wr,
  output logic [3:0]    lb_be,
  output logic [31:0]   lb_wdata,
  input  logic [31:0]   lb_rdata,
  input  logic          lb_ready
);
  tgt_e            tgt;
  logic [IDXW-1:0] idx;
  logic            is_io;
  logic            rom_hit;
  logic            miss_hit;
  logic [DW-1:0]   rom_data;
  logic [DW-1:0]   imm_data;
  logic            busy;
  logic            wd_fire;
  logic            acc_fire;

  assign req_ready = !busy && !cpl_valid;
  assign acc_fire  = req_valid && req_ready;
  assign imm_data  = rom_hit ? rom_data : '1;

  bh_decode #(
    .AW(AW), .MEM_WORDS(MEM_WORDS), .IO_WORDS(IO_WORDS),
    .ROM_SPAN(ROM_SPAN), .BAR_IO(BAR_IO)
  ) u_dec (
    .hit(req_hit), .addr(req_addr), .tgt(tgt), .idx(idx),
    .is_io(is_io), .rom_hit(rom_hit), .miss_hit(miss_hit)
  );

  bh_rom #(.AW(AW), .ROM_WORDS(ROM_WORDS)) u_rom (
    .widx(req_addr[AW-1:2]), .data(rom_data)
  );

  bh_lbus_fsm #(.AW(AW), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc_fire), .tgt(tgt), .idx(idx),
    .is_io(is_io), .wr(req_wr), .addr(req_addr), .be(req_be),
    .wdata(req_wdata), .imm_data(imm_data), .lb_ready(lb_ready),
    .lb_rdata(lb_rdata), .lb_cs(lb_cs), .lb_addr(lb_addr), .lb_wr(lb_wr),
    .lb_be(lb_be), .lb_wdata(lb_wdata), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .busy(busy), .wd_fire(wd_fire)
  );

  // R6
  rom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && rom_hit) |=> ((lb_cs == '0) && (cpl_valid == !$past(req_wr))));

  // R7
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && miss_hit && !req_wr) |=> (cpl_valid && (cpl_data == '1)));

  // R10
  be_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_wr && (req_be == '0)) |=> (lb_cs == '0));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_cs != '0) |-> !req_ready);
endmodule

// File: tb/barhit_lbus_bridge_tb.sv
`timescale 1ns/1ps
module barhit_lbus_bridge_tb;
  localparam int TO = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_hit = '0;
  logic [15:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        cpl_valid;
  logic [31:0] cpl_data;
  logic [5:0]  lb_cs;
  logic [15:0] lb_addr;
  logic        lb_wr;
  logic [3:0]  lb_be;
  logic [31:0] lb_wdata;
  logic [31:0] lb_rdata;
  logic        lb_ready;

  always #2 clk = ~clk;

  barhit_lbus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hit(req_hit), .req_addr(req_addr), .req_wr(req_wr), .req_be(req_be),
    .req_wdata(req_wdata), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .lb_cs(lb_cs), .lb_addr(lb_addr), .lb_wr(lb_wr), .lb_be(lb_be),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ready(lb_ready)
  );

  // local target model: answers after resp_delay cycles of select (-1 = never)
  int resp_delay = 2;
  int busy_cnt = 0;
  always @(posedge clk) busy_cnt <= (lb_cs != 0) ? busy_cnt + 1 : 0;
  assign lb_ready = (lb_cs != 0) && (busy_cnt == resp_delay);

  function automatic logic [7:0] cs_index(input logic [5:0] cs);
    logic [7:0] r = 8'h0;
    for (int i = 0; i < 6; i++) if (cs[i]) r = 8'(i);
    return r;
  endfunction
  assign lb_rdata = {8'hB0 + cs_index(lb_cs), 8'h00, lb_addr};

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // observations of the last request
  int          n_cpl, cs_cyc, cpl_lat;
  bit          rdy_busy;
  logic [31:0] got_data, got_wd;
  logic [5:0]  got_cs;
  logic [15:0] got_addr;
  logic [3:0]  got_be;
  logic        got_wr;

  task automatic run_req(input logic [6:0] hit, input logic [15:0] addr,
                         input logic wr, input logic [3:0] be,
                         input logic [31:0] wd, input int win);
    int guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_hit = hit; req_addr = addr;
    req_wr = wr; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n_cpl = 0; cs_cyc = 0; cpl_lat = -1; rdy_busy = 0;
    got_data = '0; got_wd = '0; got_cs = '0; got_addr = '0; got_be = '0; got_wr = 0;
    for (int k = 1; k <= win; k++) begin
      if (cpl_valid) begin
        n_cpl++; got_data = cpl_data;
        if (cpl_lat < 0) cpl_lat = k;
        if (req_ready) rdy_busy = 1;
      end
      if (lb_cs != 0) begin
        cs_cyc++; got_cs = lb_cs; got_addr = lb_addr;
        got_be = lb_be; got_wd = lb_wdata; got_wr = lb_wr;
        if (req_ready) rdy_busy = 1;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [6:0]  hit;
    logic [15:0] addr;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        ecpl;
    logic [31:0] edata;
    logic [5:0]  ecs;
    logic [31:0] ewd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // R2 plain reads, unaligned offset, priority
    '{4'd2, 7'h01, 16'h0010, 1'b0, 4'hF, 32'h0, 1'b1, 32'hB000_0010, 6'h01, 32'h0},
    '{4'd2, 7'h20, 16'h0FFC, 1'b0, 4'hF, 32'h0, 1'b1, 32'hB500_0FFC, 6'h20, 32'h0},
    '{4'd2, 7'h0A, 16'h0020, 1'b0, 4'hF, 32'h0, 1'b1, 32'hB100_0020, 6'h02, 32'h0},
    '{4'd2, 7'h48, 16'h0008, 1'b0, 4'hF, 32'h0, 1'b1, 32'hB300_0008, 6'h08, 32'h0},
    '{4'd2, 7'h01, 16'h0013, 1'b0, 4'h3, 32'h0, 1'b1, 32'hB000_0010, 6'h01, 32'h0},
    // R3 window edges
    '{4'd3, 7'h08, 16'h1000, 1'b0, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, 6'h00, 32'h0},
    '{4'd3, 7'h04, 16'h00FC, 1'b0, 4'hF, 32'h0, 1'b1, 32'hB200_00FC, 6'h04, 32'h0},
    '{4'd3, 7'h04, 16'h0100, 1'b0, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, 6'h00, 32'h0},
    // R6 option ROM
    '{4'd6, 7'h40, 16'h0000, 1'b0, 4'hF, 32'h0, 1'b1, 32'h5A00_FF3C, 6'h00, 32'h0},
    '{4'd6, 7'h40, 16'h003C, 1'b0, 4'hF, 32'h0, 1'b1, 32'h5A0F_F033, 6'h00, 32'h0},
    '{4'd6, 7'h40, 16'h0040, 1'b0, 4'hF, 32'h0, 1'b1, 32'h0000_0000, 6'h00, 32'h0},
    '{4'd6, 7'h40, 16'h03FC, 1'b0, 4'hF, 32'h0, 1'b1, 32'h0000_0000, 6'h00, 32'h0},
    // R7 unimplemented and no hit
    '{4'd7, 7'h40, 16'h0400, 1'b0, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, 6'h00, 32'h0},
    '{4'd7, 7'h00, 16'h0010, 1'b0, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, 6'h00, 32'h0},
    // R9 writes: memory posted, I/O completed
    '{4'd9, 7'h10, 16'h0100, 1'b1, 4'hF, 32'h1234_5678, 1'b0, 32'h0, 6'h10, 32'h1234_5678},
    '{4'd9, 7'h04, 16'h0010, 1'b1, 4'hC, 32'hAABB_CCDD, 1'b1, 32'h0, 6'h04, 32'hAABB_0000},
    // R10 lane gating, empty enables
    '{4'd10, 7'h02, 16'h0004, 1'b1, 4'h5, 32'h1122_3344, 1'b0, 32'h0, 6'h02, 32'h0022_0044},
    '{4'd10, 7'h01, 16'h0000, 1'b1, 4'h0, 32'hDEAD_BEEF, 1'b0, 32'h0, 6'h00, 32'h0},
    '{4'd9, 7'h04, 16'h0008, 1'b1, 4'h0, 32'hDEAD_BEEF, 1'b1, 32'h0, 6'h00, 32'h0},
    // R8 writes that must stay off the local bus
    '{4'd8, 7'h40, 16'h0000, 1'b1, 4'hF, 32'hCAFE_0001, 1'b0, 32'h0, 6'h00, 32'h0},
    '{4'd8, 7'h00, 16'h0000, 1'b1, 4'hF, 32'hCAFE_0002, 1'b0, 32'h0, 6'h00, 32'h0},
    '{4'd8, 7'h04, 16'h0200, 1'b1, 4'hF, 32'hCAFE_0003, 1'b1, 32'h0, 6'h00, 32'h0}
  };

  initial begin
    #(200000 * 4);
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'h1);
    chk(lb_cs == 6'h0, "R1", "lb_cs in reset", 32'(lb_cs), 32'h0);
    chk(cpl_valid == 1'b0, "R1", "cpl_valid in reset", 32'(cpl_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);

    // table walk
    resp_delay = 2;
    for (int v = 0; v < NV; v++) begin
      rq = $sformatf("R%0d", VEC[v].rq);
      run_req(VEC[v].hit, VEC[v].addr, VEC[v].wr, VEC[v].be, VEC[v].wd, 12);
      chk(n_cpl == 32'(VEC[v].ecpl), rq, $sformatf("vec%0d completions", v),
          32'(n_cpl), 32'(VEC[v].ecpl));
      if (VEC[v].ecpl)
        chk(got_data == VEC[v].edata, rq, $sformatf("vec%0d cpl_data", v),
            got_data, VEC[v].edata);
      chk((cs_cyc > 0) == (VEC[v].ecs != 0), rq, $sformatf("vec%0d bus used", v),
          32'(cs_cyc), 32'(VEC[v].ecs != 0));
      if (VEC[v].ecs != 0) begin
        chk(got_cs == VEC[v].ecs, rq, $sformatf("vec%0d lb_cs", v),
            32'(got_cs), 32'(VEC[v].ecs));
        chk(got_addr == {VEC[v].addr[15:2], 2'b00}, rq, $sformatf("vec%0d lb_addr", v),
            32'(got_addr), 32'({VEC[v].addr[15:2], 2'b00}));
        chk(got_wr == VEC[v].wr, rq, $sformatf("vec%0d lb_wr", v),
            32'(got_wr), 32'(VEC[v].wr));
        if (VEC[v].wr) begin
          chk(got_wd == VEC[v].ewd, rq, $sformatf("vec%0d lb_wdata", v),
              got_wd, VEC[v].ewd);
          chk(got_be == VEC[v].be, rq, $sformatf("vec%0d lb_be", v),
              32'(got_be), 32'(VEC[v].be));
        end
      end
    end

    // R6 latency from the table, no local access
    run_req(7'h40, 16'h0004, 1'b0, 4'hF, 32'h0, 6);
    chk(cpl_lat == 1, "R6", "rom latency", 32'(cpl_lat), 32'd1);
    chk(got_data == 32'h5A01_FE3D, "R6", "rom word 1", got_data, 32'h5A01_FE3D);
    chk(cs_cyc == 0, "R6", "rom bus idle", 32'(cs_cyc), 32'd0);

    // R7 latency for a miss
    run_req(7'h00, 16'h0000, 1'b0, 4'hF, 32'h0, 6);
    chk(cpl_lat == 1, "R7", "miss latency", 32'(cpl_lat), 32'd1);

    // R4 hold until ready, completion in release cycle
    resp_delay = 5;
    run_req(7'h01, 16'h0040, 1'b0, 4'hF, 32'h0, 16);
    chk(cs_cyc == 6, "R4", "select held cycles d=5", 32'(cs_cyc), 32'd6);
    chk(cpl_lat == 7, "R4", "completion cycle d=5", 32'(cpl_lat), 32'd7);
    chk(got_data == 32'hB000_0040, "R4", "read data d=5", got_data, 32'hB000_0040);
    // R11 busy window and pulse
    chk(rdy_busy == 0, "R11", "req_ready while busy", 32'(rdy_busy), 32'd0);
    chk(n_cpl == 1, "R11", "single completion pulse", 32'(n_cpl), 32'd1);
    resp_delay = 0;
    run_req(7'h02, 16'h0008, 1'b0, 4'hF, 32'h0, 8);
    chk(cs_cyc == 1, "R4", "select held cycles d=0", 32'(cs_cyc), 32'd1);
    chk(cpl_lat == 2, "R4", "completion cycle d=0", 32'(cpl_lat), 32'd2);

    // R5 timeout on read, I/O write, memory write
    resp_delay = -1;
    run_req(7'h02, 16'h0010, 1'b0, 4'hF, 32'h0, TO + 20);
    chk(cs_cyc == TO, "R5", "read select cycles", 32'(cs_cyc), 32'(TO));
    chk(cpl_lat == TO + 1, "R5", "read completion cycle", 32'(cpl_lat), 32'(TO + 1));
    chk(got_data == 32'hFFFF_FFFF, "R5", "read timeout data", got_data, 32'hFFFF_FFFF);
    run_req(7'h04, 16'h0010, 1'b1, 4'hF, 32'h5555_AAAA, TO + 20);
    chk(n_cpl == 1 && got_data == 32'h0, "R5", "io write timeout cpl",
        32'(n_cpl), 32'd1);
    chk(cpl_lat == TO + 1, "R5", "io write completion cycle", 32'(cpl_lat), 32'(TO + 1));
    run_req(7'h08, 16'h0010, 1'b1, 4'hF, 32'h5555_AAAA, TO + 20);
    chk(n_cpl == 0, "R5", "mem write timeout no cpl", 32'(n_cpl), 32'd0);
    chk(cs_cyc == TO, "R5", "mem write select cycles", 32'(cs_cyc), 32'(TO));

    // R2 bridge usable after timeout
    resp_delay = 1;
    run_req(7'h20, 16'h0100, 1'b0, 4'hF, 32'h0, 10);
    chk(got_data == 32'hB500_0100, "R2", "read after timeout", got_data, 32'hB500_0100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule